// File: doc/BRIEF.md
# Multi-Mode Barrel Shift Unit

This block is the shifter of a 64-bit processing element. Every operation is carried out by one right rotator followed by a keep-mask. A left shift by N is turned into an equivalent right amount: N-1 is formed and then one's-complemented. The vacated positions of an end-off shift are cleared by the mask.

One stage serves several kinds of operation:
- whole-word rotates, and end-off shifts that fill with zeros;
- mantissa-only shifts, which leave the exponent and sign bits alone;
- a 128-bit double-length end-off shift over the register pair A:B.

In 32-bit mode the word splits into two independent 32-bit halves. Each half has its own enable, and an enable that is off freezes its half. The shifted result is computed combinationally and captured into the result registers on a load strobe.

Bit numbering in this brief follows the word convention: word bit 0 is the most significant bit (port bit 63), and word bit 63 is port bit 0. A right shift moves bits toward higher word bit numbers, which is toward the port LSB.

Top module: `rotshift_unit`

## Requirements
- R1: After reset is asserted (rst_n low), res_a and res_b read zero.
- R2: The result registers change only on a rising clock edge with load high. With load low they hold their values, whatever the other inputs do.
- R3: dir_sel[1] selects left (1) or right (0) and dir_sel[0] selects end-off (1) or end-around (0). When op_kind is 00 (or the unused code 11), the word shift acts on opnd_a. In an end-around shift, bits leaving one end re-enter at the other.
- R4: An end-off word shift by N clears the N positions it vacates: the top N port bits on a right shift, the bottom N port bits on a left shift. The bits shifted out are lost.
- R5: The shift count is taken modulo 64 in 64-bit mode (mode32=0) and modulo 32 in 32-bit mode (only shift_cnt[4:0] is used). Any effective count of 0 returns the operands unchanged.
- R6: In 32-bit mode, a word shift acts on port bits 63:32 and port bits 31:0 separately, and no bit crosses between the halves.
- R7: op_kind 01 is a mantissa shift, always end-off, with dir_sel[0] ignored. In 64-bit mode it moves only word bits 16..63 (port bits 47:0), and port bits 63:48 keep their value.
- R8: A mantissa shift whose count exceeds the field width forces that mantissa field to zero. The width is 48 in 64-bit mode and 24 per half in 32-bit mode.
- R9: In 32-bit mode a mantissa shift uses two 24-bit fields, word bits 8..31 (port 55:32) and word bits 40..63 (port 23:0). The other bits of each half stay unchanged.
- R10: op_kind 10 is a double-length end-off shift of the 128-bit value {opnd_a, opnd_b}, with A holding the upper half. Its result is split back into res_a and res_b, and dir_sel[0] is ignored.
- R11: A double-length request made in 32-bit mode, or with en_hi different from en_lo, leaves both A and B unchanged.
- R12: With en_hi low, res_a[63:32] (and res_b[63:32] for a double shift) takes the operand value unchanged. en_lo does the same for bits 31:0.
- R13: For every operation other than a double-length shift, res_b captures opnd_b unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture strobe for the result registers |
| opnd_a | input | 64 | Operand register A |
| opnd_b | input | 64 | Operand register B (low half of a double shift) |
| shift_cnt | input | 6 | Shift count N |
| dir_sel | input | 2 | [1] left, [0] end-off |
| mode32 | input | 1 | 1 selects two 32-bit halves |
| op_kind | input | 2 | 00 word, 01 mantissa, 10 double-length, 11 treated as word |
| en_hi | input | 1 | Enable for port bits 63:32 |
| en_lo | input | 1 | Enable for port bits 31:0 |
| res_a | output | 64 | Registered result for A |
| res_b | output | 64 | Registered result for B |

## Verification
The bench targets count 0 and counts at and just past the mantissa widths (48/49 and 24/25). A design with a bad left-count conversion would move left shifts by one place too few or too many, and one that trusted the natural shift limit incorrectly would leave stray bits in an oversized mantissa shift. It also drives maximum counts of 63 and 31, where a rotator that fails to wrap would lose bits and a mask built one position wrong would keep or drop a single edge bit. Double-length requests with unequal enables or in 32-bit mode are aimed at a design that shifts anyway. Frozen halves and 32-bit halves check that no bit leaks across the middle of the word.

// File: rtl/rotshift_pkg.sv
package rotshift_pkg;
   typedef enum logic [1:0] {
      OPK_WORD = 2'b00,
      OPK_MANT = 2'b01,
      OPK_DBL  = 2'b10,
      OPK_RSVD = 2'b11
   } opk_e;

   localparam int unsigned DIR_LEFT_BIT = 1;
   localparam int unsigned DIR_EOFF_BIT = 0;
endpackage

// File: rtl/rotshift_cnt_xform.sv
// Converts a shift count into the equivalent right-rotate amount.
module rotshift_cnt_xform #(
   parameter int unsigned CW = 6
) (
   input  logic [CW-1:0] cnt,
   input  logic          left,
   output logic [CW-1:0] ramt
);
   logic [CW-1:0] cnt_m1;

   // left by N == right by ~(N-1) modulo 2**CW
   assign cnt_m1 = cnt - CW'(1);
   assign ramt   = left ? ~cnt_m1 : cnt;
endmodule

// File: rtl/rotshift_rotr.sv
// Logarithmic right rotator, one stage per count bit.
module rotshift_rotr #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0]         din,
   input  logic [$clog2(W)-1:0] amt,
   output logic [W-1:0]         dout
);
   localparam int unsigned STG = $clog2(W);

   logic [W-1:0] stage [0:STG];

   assign stage[0] = din;

   for (genvar k = 0; k < STG; k++) begin : g_stage
      localparam int unsigned SH = 1 << k;
      assign stage[k+1] = amt[k] ? {stage[k][SH-1:0], stage[k][W-1:SH]} : stage[k];
   end

   assign dout = stage[STG];
endmodule

// File: rtl/rotshift_lane.sv
// One shift lane: field extract, right rotate, end-off keep mask, field merge.
module rotshift_lane #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0]         val,
   input  logic [$clog2(W)-1:0] cnt,
   input  logic                 left,
   input  logic                 endoff,
   input  logic [W-1:0]         fmask,
   output logic [W-1:0]         res
);
   localparam int unsigned CW = $clog2(W);

   if ((1 << CW) != W) begin : g_bad_width
      $error("rotshift_lane: W must be a power of two");
   end

   logic [CW-1:0] ramt;
   logic [W-1:0]  field;
   logic [W-1:0]  rot;
   logic [W-1:0]  keep;

   rotshift_cnt_xform #(.CW(CW)) u_cnt (
      .cnt  (cnt),
      .left (left),
      .ramt (ramt)
   );

   assign field = val & fmask;

   rotshift_rotr #(.W(W)) u_rot (
      .din  (field),
      .amt  (ramt),
      .dout (rot)
   );

   always_comb begin
      if (!endoff)
         keep = '1;
      else if (left)
         keep = (fmask << cnt) & fmask;
      else
         keep = fmask >> cnt;
   end

   assign res = (rot & keep & fmask) | (val & ~fmask);
endmodule

// File: rtl/rotshift_unit.sv
module rotshift_unit
   import rotshift_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned MANT_W  = 48,
   parameter int unsigned HMANT_W = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [DATA_W-1:0]           opnd_a,
   input  logic [DATA_W-1:0]           opnd_b,
   input  logic [$clog2(DATA_W)-1:0]   shift_cnt,
   input  logic [1:0]                  dir_sel,
   input  logic                        mode32,
   input  logic [1:0]                  op_kind,
   input  logic                        en_hi,
   input  logic                        en_lo,
   output logic [DATA_W-1:0]           res_a,
   output logic [DATA_W-1:0]           res_b
);
   localparam int unsigned HALF_W = DATA_W / 2;
   localparam int unsigned DBL_W  = DATA_W * 2;
   localparam int unsigned CW     = $clog2(DATA_W);
   localparam int unsigned HCW    = $clog2(HALF_W);
   localparam int unsigned DCW    = $clog2(DBL_W);
   localparam logic [DATA_W-1:0] MANT_MASK  = {{(DATA_W-MANT_W){1'b0}}, {MANT_W{1'b1}}};
   localparam logic [HALF_W-1:0] HMANT_MASK = {{(HALF_W-HMANT_W){1'b0}}, {HMANT_W{1'b1}}};

   if ((1 << CW) != DATA_W) begin : g_bad_data_w
      $error("rotshift_unit: DATA_W must be a power of two");
   end
   if (MANT_W >= DATA_W || HMANT_W >= HALF_W) begin : g_bad_mant_w
      $error("rotshift_unit: mantissa widths must leave room for the exponent");
   end

   opk_e kind;
   logic is_mant, is_dbl, left, eoff, dbl_ok;

   assign kind    = opk_e'(op_kind);
   assign is_mant = (kind == OPK_MANT);
   assign is_dbl  = (kind == OPK_DBL);
   assign left    = dir_sel[DIR_LEFT_BIT];
   assign eoff    = dir_sel[DIR_EOFF_BIT] | is_mant;
   assign dbl_ok  = !mode32 && (en_hi == en_lo);

   // full-width lane
   logic [DATA_W-1:0] w_res;
   rotshift_lane #(.W(DATA_W)) u_word (
      .val    (opnd_a),
      .cnt    (shift_cnt),
      .left   (left),
      .endoff (eoff),
      .fmask  (is_mant ? MANT_MASK : {DATA_W{1'b1}}),
      .res    (w_res)
   );

   // two independent half lanes for 32-bit mode
   logic [DATA_W-1:0] h_res;
   for (genvar h = 0; h < 2; h++) begin : g_half
      rotshift_lane #(.W(HALF_W)) u_half (
         .val    (opnd_a[h*HALF_W +: HALF_W]),
         .cnt    (shift_cnt[HCW-1:0]),
         .left   (left),
         .endoff (eoff),
         .fmask  (is_mant ? HMANT_MASK : {HALF_W{1'b1}}),
         .res    (h_res[h*HALF_W +: HALF_W])
      );
   end

   // double-length lane over {A,B}, always end-off
   logic [DBL_W-1:0] d_res;
   rotshift_lane #(.W(DBL_W)) u_dbl (
      .val    ({opnd_a, opnd_b}),
      .cnt    (DCW'(shift_cnt)),
      .left   (left),
      .endoff (1'b1),
      .fmask  ({DBL_W{1'b1}}),
      .res    (d_res)
   );

   logic [DATA_W-1:0] pre_a, pre_b;
   always_comb begin
      if (is_dbl) begin
         if (dbl_ok) {pre_a, pre_b} = d_res;
         else        {pre_a, pre_b} = {opnd_a, opnd_b};
      end else begin
         pre_a = mode32 ? h_res : w_res;
         pre_b = opnd_b;
      end
   end

   // per-half enable freeze
   logic [1:0]        half_en;
   logic [DATA_W-1:0] nxt_a, nxt_b;
   assign half_en = {en_hi, en_lo};
   for (genvar h = 0; h < 2; h++) begin : g_en
      assign nxt_a[h*HALF_W +: HALF_W] = half_en[h] ? pre_a[h*HALF_W +: HALF_W]
                                                    : opnd_a[h*HALF_W +: HALF_W];
      assign nxt_b[h*HALF_W +: HALF_W] = half_en[h] ? pre_b[h*HALF_W +: HALF_W]
                                                    : opnd_b[h*HALF_W +: HALF_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_a <= '0;
         res_b <= '0;
      end else if (load) begin
         res_a <= nxt_a;
         res_b <= nxt_b;
      end
   end
endmodule

// File: rtl/rotshift_chk.sv
module rotshift_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        load,
   input logic [63:0] opnd_a,
   input logic [63:0] opnd_b,
   input logic [5:0]  shift_cnt,
   input logic [1:0]  dir_sel,
   input logic        mode32,
   input logic [1:0]  op_kind,
   input logic        en_hi,
   input logic        en_lo,
   input logic [63:0] res_a,
   input logic [63:0] res_b
);
   AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(res_a) && $stable(res_b))); // R2

   AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (load && op_kind == 2'b00 && !dir_sel[0] && en_hi && en_lo)
      |=> ($countones(res_a) == $countones($past(opnd_a)))); // R3

   AST_ENDOFF_RIGHT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !mode32 && op_kind == 2'b00 && dir_sel == 2'b01 && en_hi && en_lo)
      |=> ((res_a & ~(64'hFFFF_FFFF_FFFF_FFFF >> $past(shift_cnt))) == 64'd0)); // R4

   AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (mode32 ? (shift_cnt[4:0] == 5'd0) : (shift_cnt == 6'd0)))
      |=> (res_a == $past(opnd_a) && res_b == $past(opnd_b))); // R5

   AST_MANT_EXP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !mode32 && op_kind == 2'b01)
      |=> (res_a[63:48] == $past(opnd_a[63:48]))); // R7

   AST_MANT_OVERSIZE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !mode32 && op_kind == 2'b01 && shift_cnt > 6'd48 && en_hi && en_lo)
      |=> (res_a[47:0] == 48'd0)); // R8

   AST_DBL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (load && op_kind == 2'b10 && (mode32 || en_hi != en_lo))
      |=> (res_a == $past(opnd_a) && res_b == $past(opnd_b))); // R11

   AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !en_hi) |=> (res_a[63:32] == $past(opnd_a[63:32]))); // R12

   AST_B_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (load && op_kind != 2'b10) |=> (res_b == $past(opnd_b))); // R13
endmodule

bind rotshift_unit rotshift_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .load      (load),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .shift_cnt (shift_cnt),
   .dir_sel   (dir_sel),
   .mode32    (mode32),
   .op_kind   (op_kind),
   .en_hi     (en_hi),
   .en_lo     (en_lo),
   .res_a     (res_a),
   .res_b     (res_b)
);

// File: tb/sim_rotshift_unit.sv
`timescale 1ns/1ps
module sim_rotshift_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [63:0] opnd_a = '0, opnd_b = '0;
   logic [5:0]  shift_cnt = '0;
   logic [1:0]  dir_sel = '0;
   logic        mode32 = 1'b0;
   logic [1:0]  op_kind = '0;
   logic        en_hi = 1'b1, en_lo = 1'b1;
   logic [63:0] res_a, res_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rotshift_unit u0 (
      .clk(clk), .rst_n(rst_n), .load(load), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .shift_cnt(shift_cnt), .dir_sel(dir_sel), .mode32(mode32), .op_kind(op_kind),
      .en_hi(en_hi), .en_lo(en_lo), .res_a(res_a), .res_b(res_b)
   );

   // generic w-bit shift on the low bits of v
   function automatic logic [127:0] sh(logic [127:0] v, int w, int n, bit lf, bit rot);
      logic [127:0] m;
      m = (w >= 128) ? {128{1'b1}} : ((128'd1 << w) - 128'd1);
      v = v & m;
      if (rot && n != 0)
         return lf ? (((v << n) | (v >> (w - n))) & m) : (((v >> n) | (v << (w - n))) & m);
      return lf ? ((v << n) & m) : (v >> n);
   endfunction

   function automatic logic [127:0] mant(logic [127:0] f, int w, int n, bit lf);
      if (n > w) return '0;
      return sh(f, w, n, lf, 1'b0);
   endfunction

   function automatic logic [127:0] model(logic [63:0] a, logic [63:0] b, logic [5:0] c,
                                          logic [1:0] d, bit m32, logic [1:0] k,
                                          bit eh, bit el);
      logic [63:0]  na, nb;
      logic [127:0] t;
      bit lf, rot;
      int n;
      lf  = d[1];
      rot = !d[0];
      n   = m32 ? int'(c[4:0]) : int'(c);
      nb  = b;
      if (k == 2'b10) begin
         if (!m32 && eh == el) begin
            t  = sh({a, b}, 128, n, lf, 1'b0);
            na = t[127:64];
            nb = t[63:0];
         end else begin
            na = a;
         end
      end else if (k == 2'b01) begin
         if (m32) begin
            t = mant({104'd0, a[55:32]}, 24, n, lf);
            na[63:32] = {a[63:56], t[23:0]};
            t = mant({104'd0, a[23:0]}, 24, n, lf);
            na[31:0] = {a[31:24], t[23:0]};
         end else begin
            t  = mant({80'd0, a[47:0]}, 48, n, lf);
            na = {a[63:48], t[47:0]};
         end
      end else begin
         if (m32) begin
            t = sh({96'd0, a[63:32]}, 32, n, lf, rot);
            na[63:32] = t[31:0];
            t = sh({96'd0, a[31:0]}, 32, n, lf, rot);
            na[31:0] = t[31:0];
         end else begin
            t  = sh({64'd0, a}, 64, n, lf, rot);
            na = t[63:0];
         end
      end
      if (!eh) begin na[63:32] = a[63:32]; nb[63:32] = b[63:32]; end
      if (!el) begin na[31:0]  = a[31:0];  nb[31:0]  = b[31:0];  end
      return {na, nb};
   endfunction

   task automatic compare(logic [63:0] ea, logic [63:0] eb, string tag);
      checks++;
      if (res_a !== ea || res_b !== eb) begin
         errors++;
         $display("FAIL %s: got a=%h b=%h expected a=%h b=%h", tag, res_a, res_b, ea, eb);
      end
   endtask

   task automatic run_op(logic [63:0] a, logic [63:0] b, logic [5:0] c, logic [1:0] d,
                         bit m32, logic [1:0] k, bit eh, bit el, string tag);
      logic [127:0] e;
      @(negedge clk);
      opnd_a = a; opnd_b = b; shift_cnt = c; dir_sel = d;
      mode32 = m32; op_kind = k; en_hi = eh; en_lo = el; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      e = model(a, b, c, d, m32, k, eh, el);
      compare(e[127:64], e[63:0], tag);
   endtask

   localparam logic [63:0] PAT  = 64'h8123_4567_89AB_CDEF;
   localparam logic [63:0] PATB = 64'hF00D_CAFE_1357_9BDF;

   initial begin
      logic [63:0] ha, hb;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (res_a !== 64'd0 || res_b !== 64'd0) begin
         errors++;
         $display("FAIL R1: got a=%h b=%h expected a=0 b=0", res_a, res_b);
      end
      rst_n = 1'b1;

      run_op(PAT, PATB, 6'd4,  2'b00, 0, 2'b00, 1, 1, "R3 rotate right 4");
      run_op(PAT, PATB, 6'd4,  2'b10, 0, 2'b00, 1, 1, "R3 rotate left 4");
      run_op(PAT, PATB, 6'd63, 2'b10, 0, 2'b00, 1, 1, "R3 rotate left 63");
      run_op(PAT, PATB, 6'd12, 2'b01, 0, 2'b00, 1, 1, "R4 end-off right 12");
      run_op(PAT, PATB, 6'd63, 2'b11, 0, 2'b00, 1, 1, "R4 end-off left 63");
      run_op(PAT, PATB, 6'd0,  2'b11, 0, 2'b00, 1, 1, "R5 left count 0");
      run_op(PAT, PATB, 6'd32, 2'b10, 1, 2'b00, 1, 1, "R5 mod 32 count 32");
      run_op(PAT, PATB, 6'd35, 2'b01, 1, 2'b00, 1, 1, "R5 mod 32 count 35");
      run_op(PAT, PATB, 6'd8,  2'b00, 1, 2'b00, 1, 1, "R6 halves rotate");
      run_op(PAT, PATB, 6'd31, 2'b11, 1, 2'b00, 1, 1, "R6 halves end-off left 31");
      run_op(PAT, PATB, 6'd5,  2'b00, 0, 2'b01, 1, 1, "R7 mantissa right 5");
      run_op(PAT, PATB, 6'd47, 2'b10, 0, 2'b01, 1, 1, "R7 mantissa left 47");
      run_op(PAT, PATB, 6'd48, 2'b01, 0, 2'b01, 1, 1, "R8 mantissa count 48");
      run_op(PAT, PATB, 6'd49, 2'b11, 0, 2'b01, 1, 1, "R8 mantissa count 49");
      run_op(PAT, PATB, 6'd25, 2'b01, 1, 2'b01, 1, 1, "R8 half mantissa count 25");
      run_op(PAT, PATB, 6'd24, 2'b11, 1, 2'b01, 1, 1, "R9 half mantissa left 24");
      run_op(PAT, PATB, 6'd7,  2'b01, 1, 2'b01, 1, 1, "R9 half mantissa right 7");
      run_op(PAT, PATB, 6'd20, 2'b01, 0, 2'b10, 1, 1, "R10 double right 20");
      run_op(PAT, PATB, 6'd63, 2'b10, 0, 2'b10, 1, 1, "R10 double left 63");
      run_op(PAT, PATB, 6'd9,  2'b11, 1, 2'b10, 1, 1, "R11 double in 32-bit mode");
      run_op(PAT, PATB, 6'd9,  2'b11, 0, 2'b10, 1, 0, "R11 double unequal enables");
      run_op(PAT, PATB, 6'd9,  2'b11, 0, 2'b00, 0, 1, "R12 hi half frozen");
      run_op(PAT, PATB, 6'd9,  2'b00, 1, 2'b00, 1, 0, "R12 lo half frozen");
      run_op(PAT, PATB, 6'd9,  2'b01, 0, 2'b10, 0, 0, "R12 double both frozen");
      run_op(PAT, PATB, 6'd17, 2'b01, 0, 2'b00, 1, 1, "R13 B passes through");

      // R2: inputs change without load, result must hold
      ha = res_a; hb = res_b;
      @(negedge clk);
      opnd_a = ~PAT; opnd_b = ~PATB; shift_cnt = 6'd3; op_kind = 2'b10;
      @(negedge clk);
      @(negedge clk);
      compare(ha, hb, "R2 hold without load");

      for (int i = 0; i < 400; i++) begin
         logic [63:0] ra, rb;
         logic [1:0]  rk;
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         rk = 2'($urandom_range(0, 3));
         run_op(ra, rb, 6'($urandom), 2'($urandom), 1'($urandom),
                rk, ($urandom_range(0, 4) != 0), ($urandom_range(0, 4) != 0),
                rk == 2'b10 ? "R10 random double" :
                rk == 2'b01 ? "R7 random mantissa" : "R3 random word");
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule